// File: doc/BRIEF.md
# Serial Port Control Register with Enable Handshake

This block is the control slice of a serial port. It holds the receiver and transmitter enables, a FIFO-clear request field, a line-header command strobe and the frame-format settings. It drives them to the rest of the peripheral. Software reaches it through a single-word write port and a combinational readback word.

The enables use a handshake with the peripheral's own enable input. While the peripheral is off, an enable bit takes effect at once. While the peripheral is on, setting an enable does not show on the readback. Instead the block raises a request to the unit and holds a sync-busy flag until that unit acknowledges that it has come up. The bit then reads back as 1. FIFO-clear requests produce single-cycle clear pulses. The request field stays readable until sync-busy is low, and then it clears itself. The frame-format fields can only be changed while the peripheral is off.

Top module: `ser_ctrl_reg`

## Requirements
- R1: After reset, `rd_data_o` is zero, `sync_busy_o` is 0, and every pulse, request and format output is 0.
- R2: A write with enable bit 0 (receiver) or bit 1 (transmitter) set to 1 while `periph_en_i` is 0 makes that bit read back as 1 from the next cycle. No sync-busy is raised.
- R3: A write with an enable bit set to 1 while `periph_en_i` is 1 makes the bit read back 0 and sets `sync_busy_o`. The unit request output is held high. On the first edge where that unit's acknowledge is high, the bit reads 1 and its pending state ends.
- R4: When `periph_en_i` rises while an enable bit reads 1 and that unit's acknowledge is low, the bit reads 0 and `sync_busy_o` is set until the acknowledge arrives. After that the bit reads 1.
- R5: A write with an enable bit set to 0 clears that bit on the next edge. It cancels any pending enable of that unit and raises no sync-busy.
- R6: Bits [3:2] hold the FIFO-clear request: 1 clears the TX FIFO, 2 clears the RX FIFO, 3 clears both and 0 does nothing. A nonzero write gives exactly one cycle of pulse on the selected clear output or outputs, in the cycle after the write.
- R7: The FIFO-clear field reads back the written nonzero value. It holds that value while `sync_busy_o` is 1 and returns to 0 on the first edge at which `sync_busy_o` is 0.
- R8: Bits [15:8] hold the format: [10:8] character size, 11 two stop bits, 12 odd parity, 13 IR encoding, 14 collision detect, 15 start-of-frame detect. A write updates them only while `periph_en_i` is 0. While it is 1, the write leaves them unchanged.
- R9: Bits [5:4] carry a header command, where 1 means break only and 2 means the full header. Such a write gives `hdr_cmd_o` equal to the value for one cycle, including while the peripheral is enabled. Value 3 gives nothing. The field always reads 0.
- R10: When `periph_en_i` is 0, a pending enable completes on the next edge: the bit reads 1 and the sync-busy from that unit drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register readback |
| periph_en_i | input | 1 | Peripheral enable |
| rx_ack_i | input | 1 | Receiver reports it is up |
| tx_ack_i | input | 1 | Transmitter reports it is up |
| rx_en_o | output | 1 | Receiver enable readback bit |
| tx_en_o | output | 1 | Transmitter enable readback bit |
| rx_req_o | output | 1 | Receiver enable request (enabled or pending) |
| tx_req_o | output | 1 | Transmitter enable request (enabled or pending) |
| sync_busy_o | output | 1 | An enable is waiting for acknowledge |
| tx_fifo_clr_o | output | 1 | One-cycle TX FIFO clear |
| rx_fifo_clr_o | output | 1 | One-cycle RX FIFO clear |
| hdr_cmd_o | output | 2 | One-cycle header command |
| char_size_o | output | 3 | Character size code |
| two_stop_o | output | 1 | Two stop bits |
| odd_parity_o | output | 1 | Odd parity |
| ir_enc_o | output | 1 | IR encoding |
| coll_det_o | output | 1 | Collision detect |
| sof_det_o | output | 1 | Start-of-frame detect |

## Verification
The bench targets several corner cases:
- The rising edge of the peripheral enable with enables already set. A design that ignores the edge would report enabled units that never acknowledged.
- A FIFO-clear written together with an enable while the peripheral runs. Here the field must outlive the busy window. A design that clears it at once, or that re-pulses while it is held, is caught by the readback and pulse checks.
- Format writes while the peripheral is enabled, and the reserved header code.
- A pending enable that is abandoned by dropping the peripheral enable, which must complete rather than hang busy.

Long random runs compare every output each cycle against a bench model.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
  localparam int DW      = 32;
  localparam int N_UNIT  = 2;   // 0 = receiver, 1 = transmitter
  localparam int EN_LSB  = 0;
  localparam int CLR_LSB = 2;
  localparam int CLR_W   = 2;
  localparam int HDR_LSB = 4;
  localparam int HDR_W   = 2;
  localparam int FMT_LSB = 8;
  localparam int CSZ_W   = 3;
  localparam int FMT_W   = CSZ_W + 5;

  typedef struct packed {
    logic             sof_det;
    logic             coll_det;
    logic             ir_enc;
    logic             odd_parity;
    logic             two_stop;
    logic [CSZ_W-1:0] char_size;
  } fmt_t;

  typedef enum logic [HDR_W-1:0] {
    HDR_NONE  = 2'd0,
    HDR_BREAK = 2'd1,
    HDR_FULL  = 2'd2,
    HDR_RSVD  = 2'd3
  } hdr_e;
endpackage

// File: rtl/ser_ctrl_en_chan.sv
module ser_ctrl_en_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_bit_i,
  input  logic pen_i,
  input  logic pen_rise_i,
  input  logic ack_i,
  output logic en_o,
  output logic pend_o
);
  logic en_q, pend_q, en_d, pend_d;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    if (wr_i) begin
      if (wr_bit_i && pen_i) begin
        en_d   = 1'b0;
        pend_d = 1'b1;
      end else begin
        en_d   = wr_bit_i;
        pend_d = 1'b0;
      end
    end else if (pend_q) begin
      if (!pen_i || ack_i) begin
        en_d   = 1'b1;
        pend_d = 1'b0;
      end
    end else if (en_q && pen_rise_i && !ack_i) begin
      // peripheral came up before the unit did
      en_d   = 1'b0;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  AST_EN_PEND_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_q && pend_q)); // R3
  AST_DIS_WR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wr_bit_i && !pen_i |=> en_q && !pend_q); // R2
  AST_WR0_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wr_bit_i |=> !en_q && !pend_q); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && ack_i && !wr_i |=> en_q && !pend_q); // R3
  AST_OFF_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !pen_i && !wr_i |=> en_q); // R10
  AST_RISE_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && pen_rise_i && !ack_i && !wr_i |=> pend_q && !en_q); // R4
endmodule

// File: rtl/ser_ctrl_fifo_clr.sv
module ser_ctrl_fifo_clr #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] req_i,
  input  logic         busy_i,
  output logic [W-1:0] field_o,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] field_q, pulse_q;
  logic         load;

  assign load = wr_i && (req_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= load ? req_i : '0;
      if (load)         field_q <= req_i;
      else if (!busy_i) field_q <= '0;
    end
  end

  assign field_o = field_q;
  assign pulse_o = pulse_q;

  AST_PULSE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q != '0) && !load |=> pulse_q == '0); // R6
  AST_HOLD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !load |=> $stable(field_q)); // R7
  AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !load |=> field_q == '0); // R7
endmodule

// File: rtl/ser_ctrl_fmt.sv
module ser_ctrl_fmt
  import ser_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic pen_i,
  input  fmt_t data_i,
  output fmt_t fmt_o
);
  fmt_t fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            fmt_q <= '0;
    else if (wr_i && !pen_i) fmt_q <= data_i;
  end

  assign fmt_o = fmt_q;

  AST_FMT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_i |=> $stable(fmt_q)); // R8
  AST_FMT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !pen_i |=> fmt_q == $past(data_i)); // R8
endmodule

// File: rtl/ser_ctrl_reg.sv
module ser_ctrl_reg
  import ser_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             periph_en_i,
  input  logic             rx_ack_i,
  input  logic             tx_ack_i,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             sync_busy_o,
  output logic             tx_fifo_clr_o,
  output logic             rx_fifo_clr_o,
  output logic [HDR_W-1:0] hdr_cmd_o,
  output logic [CSZ_W-1:0] char_size_o,
  output logic             two_stop_o,
  output logic             odd_parity_o,
  output logic             ir_enc_o,
  output logic             coll_det_o,
  output logic             sof_det_o
);
  logic              pen_q, pen_rise, busy;
  logic [N_UNIT-1:0] ack, en, pend;
  logic [CLR_W-1:0]  clr_field, clr_pulse;
  logic [HDR_W-1:0]  hdr_q;
  hdr_e              hdr_wr;
  fmt_t              fmt;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[DW-1:FMT_LSB+FMT_W], wr_data_i[FMT_LSB-1:HDR_LSB+HDR_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pen_q <= 1'b0;
    else         pen_q <= periph_en_i;
  end
  assign pen_rise = periph_en_i && !pen_q;
  assign ack      = {tx_ack_i, rx_ack_i};

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    ser_ctrl_en_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_en_i),
      .wr_bit_i   (wr_data_i[EN_LSB+u]),
      .pen_i      (periph_en_i),
      .pen_rise_i (pen_rise),
      .ack_i      (ack[u]),
      .en_o       (en[u]),
      .pend_o     (pend[u])
    );
  end

  assign busy = |pend;

  ser_ctrl_fifo_clr #(.W(CLR_W)) u_clr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i),
    .req_i   (wr_data_i[CLR_LSB +: CLR_W]),
    .busy_i  (busy),
    .field_o (clr_field),
    .pulse_o (clr_pulse)
  );

  ser_ctrl_fmt u_fmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i),
    .pen_i  (periph_en_i),
    .data_i (fmt_t'(wr_data_i[FMT_LSB +: FMT_W])),
    .fmt_o  (fmt)
  );

  // header command is a strobe: never stored in the readback
  assign hdr_wr = hdr_e'(wr_data_i[HDR_LSB +: HDR_W]);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hdr_q <= '0;
    else if (wr_en_i && (hdr_wr == HDR_BREAK || hdr_wr == HDR_FULL)) hdr_q <= hdr_wr;
    else hdr_q <= '0;
  end

  always_comb begin
    rd_data_o                        = '0;
    rd_data_o[EN_LSB +: N_UNIT]      = en;
    rd_data_o[CLR_LSB +: CLR_W]      = clr_field;
    rd_data_o[FMT_LSB +: FMT_W]      = fmt;
  end

  assign rx_en_o       = en[0];
  assign tx_en_o       = en[1];
  assign rx_req_o      = en[0] | pend[0];
  assign tx_req_o      = en[1] | pend[1];
  assign sync_busy_o   = busy;
  assign tx_fifo_clr_o = clr_pulse[0];
  assign rx_fifo_clr_o = clr_pulse[1];
  assign hdr_cmd_o     = hdr_q;
  assign char_size_o   = fmt.char_size;
  assign two_stop_o    = fmt.two_stop;
  assign odd_parity_o  = fmt.odd_parity;
  assign ir_enc_o      = fmt.ir_enc;
  assign coll_det_o    = fmt.coll_det;
  assign sof_det_o     = fmt.sof_det;

  AST_HDR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_cmd_o != '0) && !wr_en_i |=> hdr_cmd_o == '0); // R9
  AST_HDR_NO_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_cmd_o != 2'd3); // R9
  AST_BUSY_REQ_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_busy_o |-> (rx_req_o && !rx_en_o) || (tx_req_o && !tx_en_o)); // R3
endmodule

// File: tb/sim_ser_ctrl_reg.sv
`timescale 1ns/1ps
module sim_ser_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic        pen = 1'b0, rxa = 1'b0, txa = 1'b0;
  logic [31:0] rd;
  logic        rx_en, tx_en, rx_req, tx_req, busy, txc, rxc;
  logic [1:0]  hdr;
  logic [2:0]  csz;
  logic        tstop, oddp, ire, cold, sofd;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [1:0] m_en, m_pd;
  logic       m_pq;
  logic [1:0] m_fld, m_pulse, m_hdr;
  logic [7:0] m_fmt;

  always #10 clk = ~clk;

  ser_ctrl_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd),
    .periph_en_i(pen), .rx_ack_i(rxa), .tx_ack_i(txa),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .rx_req_o(rx_req), .tx_req_o(tx_req),
    .sync_busy_o(busy), .tx_fifo_clr_o(txc), .rx_fifo_clr_o(rxc), .hdr_cmd_o(hdr),
    .char_size_o(csz), .two_stop_o(tstop), .odd_parity_o(oddp), .ir_enc_o(ire),
    .coll_det_o(cold), .sof_det_o(sofd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0; m_pd = '0; m_pq = 1'b0; m_fld = '0; m_pulse = '0; m_hdr = '0; m_fmt = '0;
  endtask

  function automatic logic [31:0] model_rd();
    return {16'h0, m_fmt, 4'h0, m_fld, m_en};
  endfunction

  task automatic model_step();
    logic [1:0] en_n, pd_n;
    logic       rise, bsy, a;
    en_n = m_en; pd_n = m_pd;
    rise = pen && !m_pq;
    bsy  = |m_pd;
    for (int i = 0; i < 2; i++) begin
      a = (i == 0) ? rxa : txa;
      if (wr) begin
        if (wd[i] && pen) begin en_n[i] = 1'b0; pd_n[i] = 1'b1; end
        else begin en_n[i] = wd[i]; pd_n[i] = 1'b0; end
      end else if (m_pd[i]) begin
        if (!pen || a) begin en_n[i] = 1'b1; pd_n[i] = 1'b0; end
      end else if (m_en[i] && rise && !a) begin
        en_n[i] = 1'b0; pd_n[i] = 1'b1;
      end
    end
    m_pulse = (wr && wd[3:2] != 2'b00) ? wd[3:2] : 2'b00;
    if (wr && wd[3:2] != 2'b00) m_fld = wd[3:2];
    else if (!bsy)              m_fld = 2'b00;
    m_hdr = (wr && (wd[5:4] == 2'd1 || wd[5:4] == 2'd2)) ? wd[5:4] : 2'd0;
    if (wr && !pen) m_fmt = wd[15:8];
    m_pq = pen;
    m_en = en_n; m_pd = pd_n;
  endtask

  task automatic compare_all();
    chk("R3 readback", rd, model_rd());
    chk("R3 requests", {30'h0, tx_req, rx_req}, {30'h0, m_en | m_pd});
    chk("R4 sync_busy", {31'h0, busy}, {31'h0, |m_pd});
    chk("R6 clr pulses", {30'h0, rxc, txc}, {30'h0, m_pulse});
    chk("R9 hdr strobe", {30'h0, hdr}, {30'h0, m_hdr});
    chk("R8 fmt outputs", {24'h0, sofd, cold, ire, oddp, tstop, csz}, {24'h0, m_fmt});
  endtask

  // called at a negedge: drive, let the edge pass, check at the next negedge
  task automatic cyc(input logic w, input logic [31:0] d, input logic p,
                     input logic ra, input logic ta);
    wr = w; wd = d; pen = p; rxa = ra; txa = ta;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset rd", rd, 32'h0);
    chk("R1 reset busy/pulses", {27'h0, busy, txc, rxc, hdr}, 32'h0);
    chk("R1 reset fmt", {24'h0, sofd, cold, ire, oddp, tstop, csz}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(1, 32'h3, 0, 0, 0);
    chk("R2 enables set when off", {30'h0, rd[1:0]}, 32'h3);
    chk("R2 no busy", {31'h0, busy}, 32'h0);

    cyc(0, 32'h0, 1, 0, 0);
    chk("R4 rise hides enables", {30'h0, rd[1:0]}, 32'h0);
    chk("R4 rise busy", {31'h0, busy}, 32'h1);
    cyc(0, 32'h0, 1, 1, 0);
    chk("R4 rx ack", {30'h0, rd[1:0]}, 32'h1);
    chk("R4 still busy", {31'h0, busy}, 32'h1);
    cyc(0, 32'h0, 1, 0, 1);
    chk("R4 tx ack", {30'h0, rd[1:0]}, 32'h3);
    chk("R4 busy drops", {31'h0, busy}, 32'h0);

    cyc(1, 32'h1, 1, 0, 0);
    chk("R3 write1 while on", {30'h0, rd[1:0]}, 32'h0);
    chk("R3 busy", {31'h0, busy}, 32'h1);
    chk("R3 rx request", {31'h0, rx_req}, 32'h1);
    cyc(1, 32'h0, 1, 0, 0);
    chk("R5 write0 clears", {30'h0, rd[1:0]}, 32'h0);
    chk("R5 no busy", {31'h0, busy}, 32'h0);

    cyc(1, 32'h5, 1, 0, 0);
    chk("R6 tx pulse", {30'h0, rxc, txc}, 32'h1);
    chk("R7 field read", {30'h0, rd[3:2]}, 32'h1);
    cyc(0, 32'h0, 1, 0, 0);
    chk("R6 pulse ends", {30'h0, rxc, txc}, 32'h0);
    chk("R7 held busy", {30'h0, rd[3:2]}, 32'h1);
    cyc(0, 32'h0, 1, 1, 0);
    chk("R3 ack sets bit", {30'h0, rd[1:0]}, 32'h1);
    chk("R7 held at ack edge", {30'h0, rd[3:2]}, 32'h1);
    cyc(0, 32'h0, 1, 0, 0);
    chk("R7 clears when idle", {30'h0, rd[3:2]}, 32'h0);

    cyc(1, 32'h9, 0, 0, 0);
    chk("R6 rx pulse", {30'h0, rxc, txc}, 32'h2);
    cyc(0, 32'h0, 0, 0, 0);
    chk("R7 cleared", {30'h0, rd[3:2]}, 32'h0);
    cyc(1, 32'hD, 0, 0, 0);
    chk("R6 both pulses", {30'h0, rxc, txc}, 32'h3);

    cyc(1, 32'hA501, 0, 0, 0);
    chk("R8 fmt written", {24'h0, rd[15:8]}, 32'hA5);
    chk("R8 char size", {29'h0, csz}, 32'h5);
    cyc(1, 32'h3C01, 1, 0, 0);
    chk("R8 fmt frozen", {24'h0, rd[15:8]}, 32'hA5);

    cyc(1, 32'h20, 1, 0, 0);
    chk("R9 full header", {30'h0, hdr}, 32'h2);
    chk("R9 reads zero", {30'h0, rd[5:4]}, 32'h0);
    cyc(0, 32'h0, 1, 0, 0);
    chk("R9 strobe ends", {30'h0, hdr}, 32'h0);
    cyc(1, 32'h30, 1, 0, 0);
    chk("R9 reserved", {30'h0, hdr}, 32'h0);

    cyc(1, 32'h2, 1, 0, 0);
    chk("R3 tx pending", {31'h0, tx_en}, 32'h0);
    cyc(0, 32'h0, 0, 0, 0);
    chk("R10 off completes", {31'h0, tx_en}, 32'h1);
    chk("R10 busy drops", {31'h0, busy}, 32'h0);

    for (int k = 0; k < 4000; k++) begin
      logic       w, p;
      logic [31:0] d;
      w = ($urandom % 3) == 0;
      d = $urandom;
      p = (($urandom % 8) == 0) ? ~pen : pen;
      cyc(w, d, p, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule